// File: doc/BRIEF.md
# Context-Filtered TLB Purge Engine

This block is a command handle that removes translations from a small TLB. Each TLB entry is tagged with a virtual address, an address-space identifier and a hardware context number. Software programs the purge operands through a word-addressed register port: a target virtual address, a mask of don't-care address bits, an address-space identifier, a page-size code, a match-any-space flag, a purge count and a bitmap that selects the hardware contexts involved. It then writes the control word with the go bit set. The engine walks the TLB at one entry per clock and clears the valid bit of every examined entry that matches.

While the walk runs, the control word reports an active status and a non-idle phase. Software polls the status until it leaves the active code. A second go while the walk is running does not restart the engine. It marks the operation as faulted, and the fault code stays after completion. The same port also loads and reads back the TLB entries, so that there is something for the purge to act on. There is no fill or lookup path.

Top module: `tlb_purge_handle`

## Requirements
- R1: After reset the control word (word 0) reads zero and every TLB entry reads invalid (bit 63 of its metadata word is 0).
- R2: A write to word 0 with bit 0 (go) and bit 4 (opcode, 1 = invalidate) both set, while the engine is idle, gives status code 2 (active) in bits 17:16, phase 1 in bits 22:20 and go = 1 on the next cycle.
- R3: An examined entry matches only when its virtual address equals the target at every bit whose mask bit is 0. Mask bits 1 stand for don't-care positions. Address bits above the 39-bit mask are always compared.
- R4: The address-space identifier must be equal, unless the match-any-space flag (word 2, bit 40) is set.
- R5: The entry's context number must select a set bit in the context bitmap (word 4, bits 15:0).
- R6: The walk examines entries 0 upward, min(count, 16) of them. The count is word 3, bits 57:48. Any count of 16 or more, including the 10-bit maximum, covers the whole TLB. A count of 0 changes nothing.
- R7: The status stays active for exactly min(count, 16) + 1 cycles and then returns to 0 (idle). The phase then returns to 0 and go clears. The status never takes code 3.
- R8: A go write with opcode 0 (no-op) leaves the status idle and go clear on the next cycle, and changes no TLB entry.
- R9: A go write while the walk is active sets status code 1 (exception). The walk still runs to its end, finishes with status 1 and clears go.
- R10: Writes to operand words and TLB entry words are ignored while the engine is busy.
- R11: Operand words read back as written. Word 1 is the 64-bit address. Word 2 holds the identifier in bits 23:0, the page-size code in bits 36:32 and the flag in bit 40. Word 3 holds the mask in bits 38:0 and the count in bits 57:48. Word 4 holds the bitmap.
- R12: TLB entry i is at words 32+2i and 33+2i. The first word holds the virtual address. The second holds the valid bit in bit 63, the context in bits 35:32 and the identifier in bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (6) | Word address for read and write |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Combinational read data for `addr` |

## Verification
The checker assumes that software drives at most one register access per cycle and that operand words are stable across a walk. The second assumption holds because the design ignores operand writes while busy, so a bench that writes mid-walk still keeps within it. The checker also assumes the go bit is only meaningful on word 0. The stimulus reloads a known TLB pattern before each vector. Every entry has a distinct context, alternating identifiers and a high address bit set on the last entry, so each match qualifier can be isolated in turn. Go writes made during a walk are issued only after the active status has been observed.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
   localparam logic [1:0] STAT_IDLE = 2'd0;
   localparam logic [1:0] STAT_EXC  = 2'd1;
   localparam logic [1:0] STAT_ACT  = 2'd2;

   typedef enum logic [2:0] {
      PH_IDLE      = 3'd0,
      PH_PE_INVAL  = 3'd1,
      PH_INT_INVAL = 3'd2,
      PH_WAIT_DONE = 3'd3,
      PH_RESTART   = 3'd4
   } phase_e;

   localparam logic OPC_NOP = 1'b0;
   localparam logic OPC_INV = 1'b1;

   localparam int W_CTRL  = 0;
   localparam int W_VA    = 1;
   localparam int W_SEL   = 2;
   localparam int W_RANGE = 3;
   localparam int W_CTX   = 4;

   localparam int B_GO    = 0;
   localparam int B_OPC   = 4;
   localparam int B_STAT  = 16;
   localparam int B_PHASE = 20;
   localparam int B_PGSZ  = 32;
   localparam int B_GLOB  = 40;
   localparam int B_CNT   = 48;
   localparam int B_ECTX  = 32;
   localparam int B_EVAL  = 63;
endpackage

// File: rtl/tlbp_entry_match.sv
module tlbp_entry_match #(
   parameter int VA_W   = 64,
   parameter int MASK_W = 39,
   parameter int ASID_W = 24,
   parameter int CTX_N  = 16,
   localparam int CTXW  = $clog2(CTX_N)
) (
   input  logic [VA_W-1:0]   e_va,
   input  logic [ASID_W-1:0] e_asid,
   input  logic [CTXW-1:0]   e_ctx,
   input  logic              e_valid,
   input  logic [VA_W-1:0]   q_va,
   input  logic [MASK_W-1:0] q_mask,
   input  logic [ASID_W-1:0] q_asid,
   input  logic              q_any,
   input  logic [CTX_N-1:0]  q_ctxmap,
   output logic              hit
);
   logic [VA_W-1:0] care;
   logic            va_ok, asid_ok, ctx_ok;

   generate
      if (VA_W > MASK_W) begin : g_wide
         assign care = ~{{(VA_W-MASK_W){1'b0}}, q_mask};
      end else begin : g_flat
         assign care = ~q_mask[VA_W-1:0];
      end
   endgenerate

   assign va_ok   = ((e_va ^ q_va) & care) == '0;
   assign asid_ok = q_any || (e_asid == q_asid);
   assign ctx_ok  = q_ctxmap[e_ctx];
   assign hit     = e_valid && va_ok && asid_ok && ctx_ok;
endmodule

// File: rtl/tlbp_array.sv
module tlbp_array #(
   parameter int DEPTH  = 16,
   parameter int VA_W   = 64,
   parameter int ASID_W = 24,
   parameter int CTXW   = 4,
   localparam int IDXW  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [IDXW-1:0]   ld_idx,
   input  logic              ld_meta,
   input  logic [63:0]       ld_data,
   input  logic              inv_en,
   input  logic [IDXW-1:0]   inv_idx,
   input  logic [IDXW-1:0]   rd_idx,
   output logic [DEPTH-1:0]  valid_vec,
   output logic [VA_W-1:0]   rd_va,
   output logic [ASID_W-1:0] rd_asid,
   output logic [CTXW-1:0]   rd_ctx,
   output logic [VA_W-1:0]   sel_va,
   output logic [ASID_W-1:0] sel_asid,
   output logic [CTXW-1:0]   sel_ctx
);
   logic [VA_W-1:0]   va_m   [DEPTH];
   logic [ASID_W-1:0] asid_m [DEPTH];
   logic [CTXW-1:0]   ctx_m  [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            va_m[i]      <= '0;
            asid_m[i]    <= '0;
            ctx_m[i]     <= '0;
            valid_vec[i] <= 1'b0;
         end else if (ld_en && ld_idx == IDXW'(i)) begin
            if (ld_meta) begin
               valid_vec[i] <= ld_data[tlbp_pkg::B_EVAL];
               ctx_m[i]     <= ld_data[tlbp_pkg::B_ECTX +: CTXW];
               asid_m[i]    <= ld_data[ASID_W-1:0];
            end else begin
               va_m[i] <= ld_data[VA_W-1:0];
            end
         end else if (inv_en && inv_idx == IDXW'(i)) begin
            valid_vec[i] <= 1'b0;
         end
      end
   end

   assign rd_va    = va_m[rd_idx];
   assign rd_asid  = asid_m[rd_idx];
   assign rd_ctx   = ctx_m[rd_idx];
   assign sel_va   = va_m[inv_idx];
   assign sel_asid = asid_m[inv_idx];
   assign sel_ctx  = ctx_m[inv_idx];
endmodule

// File: rtl/tlbp_engine.sv
module tlbp_engine import tlbp_pkg::*; #(
   parameter int DEPTH = 16,
   parameter int CNT_W = 10,
   localparam int IDXW = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             go_opc,
   input  logic [CNT_W-1:0] count,
   output logic [1:0]       status,
   output phase_e           phase,
   output logic             busy,
   output logic             walk_en,
   output logic [IDXW-1:0]  walk_idx
);
   logic [LW-1:0] left;
   logic [LW-1:0] lim;

   assign lim     = (count >= CNT_W'(DEPTH)) ? LW'(DEPTH) : LW'(count);
   assign busy    = (phase != PH_IDLE);
   assign walk_en = (phase == PH_PE_INVAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= STAT_IDLE;
         phase    <= PH_IDLE;
         walk_idx <= '0;
         left     <= '0;
      end else if (busy) begin
         case (phase)
            PH_PE_INVAL: begin
               walk_idx <= walk_idx + 1'b1;
               left     <= left - 1'b1;
               if (left == LW'(1)) phase <= PH_WAIT_DONE;
            end
            PH_WAIT_DONE: begin
               phase <= PH_IDLE;
               if (status == STAT_ACT) status <= STAT_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
         if (go) status <= STAT_EXC;
      end else if (go) begin
         if (go_opc == OPC_INV) begin
            status   <= STAT_ACT;
            walk_idx <= '0;
            left     <= lim;
            phase    <= (lim == '0) ? PH_WAIT_DONE : PH_PE_INVAL;
         end else begin
            status <= STAT_IDLE;
         end
      end
   end
endmodule

// File: rtl/tlb_purge_handle.sv
module tlb_purge_handle import tlbp_pkg::*; #(
   parameter int DEPTH  = 16,
   parameter int VA_W   = 64,
   parameter int MASK_W = 39,
   parameter int ASID_W = 24,
   parameter int PGSZ_W = 5,
   parameter int CNT_W  = 10,
   parameter int CTX_N  = 16,
   localparam int IDXW   = $clog2(DEPTH),
   localparam int CTXW   = $clog2(CTX_N),
   localparam int ADDR_W = IDXW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       wdata,
   output logic [63:0]       rdata
);
   if (DEPTH < 4 || (1 << IDXW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (VA_W > 64 || MASK_W > VA_W || MASK_W > 48) begin : g_bad_va
      $error("address or mask width out of range");
   end
   if (ASID_W > 32 || PGSZ_W > 8 || CNT_W > 16 || DEPTH >= (1 << CNT_W)) begin : g_bad_fld
      $error("operand field width out of range");
   end
   if (CTX_N > 32 || CTXW > 8 || (1 << CTXW) != CTX_N) begin : g_bad_ctx
      $error("context count must be a power of two up to 32");
   end

   logic [VA_W-1:0]   va_r;
   logic [MASK_W-1:0] mask_r;
   logic [ASID_W-1:0] asid_r;
   logic [PGSZ_W-1:0] pgsz_r;
   logic              any_r;
   logic [CNT_W-1:0]  cnt_r;
   logic [CTX_N-1:0]  ctxmap_r;
   logic              opc_r;

   logic [1:0]        status;
   phase_e            phase;
   logic              busy, walk_en, hit, go;
   logic [IDXW-1:0]   walk_idx, rd_idx;
   logic [DEPTH-1:0]  valid_vec;
   logic [VA_W-1:0]   rd_va, sel_va;
   logic [ASID_W-1:0] rd_asid, sel_asid;
   logic [CTXW-1:0]   rd_ctx, sel_ctx;
   logic              is_ent;

   assign is_ent = addr[ADDR_W-1];
   assign rd_idx = addr[IDXW:1];
   assign go     = wr_en && (addr == ADDR_W'(W_CTRL)) && wdata[B_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_r <= '0; mask_r <= '0; asid_r <= '0; pgsz_r <= '0;
         any_r <= 1'b0; cnt_r <= '0; ctxmap_r <= '0; opc_r <= OPC_NOP;
      end else if (wr_en && !busy && !is_ent) begin
         case (addr)
            ADDR_W'(W_CTRL):  opc_r <= wdata[B_OPC];
            ADDR_W'(W_VA):    va_r  <= wdata[VA_W-1:0];
            ADDR_W'(W_SEL): begin
               asid_r <= wdata[ASID_W-1:0];
               pgsz_r <= wdata[B_PGSZ +: PGSZ_W];
               any_r  <= wdata[B_GLOB];
            end
            ADDR_W'(W_RANGE): begin
               mask_r <= wdata[MASK_W-1:0];
               cnt_r  <= wdata[B_CNT +: CNT_W];
            end
            ADDR_W'(W_CTX):   ctxmap_r <= wdata[CTX_N-1:0];
            default: ;
         endcase
      end
   end

   tlbp_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .go(go), .go_opc(wdata[B_OPC]),
      .count(cnt_r), .status(status), .phase(phase), .busy(busy),
      .walk_en(walk_en), .walk_idx(walk_idx)
   );

   tlbp_array #(.DEPTH(DEPTH), .VA_W(VA_W), .ASID_W(ASID_W), .CTXW(CTXW)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .ld_en(wr_en && !busy && is_ent), .ld_idx(rd_idx), .ld_meta(addr[0]),
      .ld_data(wdata), .inv_en(walk_en && hit), .inv_idx(walk_idx),
      .rd_idx(rd_idx), .valid_vec(valid_vec),
      .rd_va(rd_va), .rd_asid(rd_asid), .rd_ctx(rd_ctx),
      .sel_va(sel_va), .sel_asid(sel_asid), .sel_ctx(sel_ctx)
   );

   tlbp_entry_match #(.VA_W(VA_W), .MASK_W(MASK_W), .ASID_W(ASID_W), .CTX_N(CTX_N)) u_match (
      .e_va(sel_va), .e_asid(sel_asid), .e_ctx(sel_ctx), .e_valid(valid_vec[walk_idx]),
      .q_va(va_r), .q_mask(mask_r), .q_asid(asid_r), .q_any(any_r),
      .q_ctxmap(ctxmap_r), .hit(hit)
   );

   always_comb begin
      rdata = '0;
      if (is_ent) begin
         if (addr[0]) begin
            rdata[B_EVAL]          = valid_vec[rd_idx];
            rdata[B_ECTX +: CTXW]  = rd_ctx;
            rdata[ASID_W-1:0]      = rd_asid;
         end else begin
            rdata[VA_W-1:0] = rd_va;
         end
      end else begin
         case (addr)
            ADDR_W'(W_CTRL): begin
               rdata[B_GO]         = busy;
               rdata[B_OPC]        = opc_r;
               rdata[B_STAT +: 2]  = status;
               rdata[B_PHASE +: 3] = phase;
            end
            ADDR_W'(W_VA): rdata[VA_W-1:0] = va_r;
            ADDR_W'(W_SEL): begin
               rdata[ASID_W-1:0]       = asid_r;
               rdata[B_PGSZ +: PGSZ_W] = pgsz_r;
               rdata[B_GLOB]           = any_r;
            end
            ADDR_W'(W_RANGE): begin
               rdata[MASK_W-1:0]      = mask_r;
               rdata[B_CNT +: CNT_W]  = cnt_r;
            end
            ADDR_W'(W_CTX): rdata[CTX_N-1:0] = ctxmap_r;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tlb_purge_handle_chk.sv
module tlb_purge_handle_chk import tlbp_pkg::*; #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [63:0]       wdata,
   input logic [1:0]        status,
   input logic              busy,
   input logic [DEPTH-1:0]  valid_vec
);
   localparam int RW = $clog2(DEPTH + 3) + 1;
   logic [RW-1:0] run_len;
   logic          ctl_go;

   assign ctl_go = wr_en && addr == ADDR_W'(W_CTRL) && wdata[B_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else run_len <= '0;
   end

   p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status != 2'd3);
   p_active_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> status != STAT_ACT);
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_go && wdata[B_OPC]) |=> (busy && status == STAT_ACT));
   p_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_go && !wdata[B_OPC]) |=> (!busy && status == STAT_IDLE && $stable(valid_vec)));
   p_reissue_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctl_go) |=> status == STAT_EXC);
   p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((valid_vec & ~$past(valid_vec)) == '0));
   p_idle_no_purge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (($past(valid_vec) & ~valid_vec) == '0));
   p_walk_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= RW'(DEPTH + 1));
endmodule

bind tlb_purge_handle tlb_purge_handle_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .status(status), .busy(busy), .valid_vec(valid_vec)
);

// File: tb/tlb_purge_handle_test.sv
`timescale 1ns/100ps
module tlb_purge_handle_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [5:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tlb_purge_handle uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata));

   typedef struct packed {
      logic [63:0] va;
      logic [38:0] mask;
      logic [23:0] asid;
      logic        any;
      logic [15:0] ctxm;
      logic [9:0]  n;
      logic [15:0] keep;
   } vec_t;

   localparam vec_t VT [9] = '{
      '{64'h4000_3000, 39'h0,      24'd7, 1'b0, 16'hFFFF, 10'd1023, 16'hFFF7},
      '{64'h4000_0000, 39'hF000,   24'd5, 1'b0, 16'hFFFF, 10'd1023, 16'hAAAA},
      '{64'h4000_0000, 39'hF000,   24'd5, 1'b1, 16'hFFFF, 10'd1023, 16'h8000},
      '{64'h4000_0000, 39'hF000,   24'd9, 1'b1, 16'h00F0, 10'd16,   16'hFF0F},
      '{64'h4000_0000, 39'hF000,   24'd9, 1'b1, 16'hFFFF, 10'd5,    16'hFFE0},
      '{64'h4000_0000, 39'hF000,   24'd9, 1'b1, 16'hFFFF, 10'd0,    16'hFFFF},
      '{64'h0,         {39{1'b1}}, 24'd0, 1'b1, 16'hFFFF, 10'd1023, 16'h8000},
      '{64'h1 << 50,   {39{1'b1}}, 24'd0, 1'b1, 16'hFFFF, 10'd1023, 16'h7FFF},
      '{64'h4000_3000, 39'h0,      24'd7, 1'b0, 16'hFFFF, 10'd3,    16'hFFFF}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 6'(a); wdata = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [63:0] d);
      @(negedge clk);
      addr = 6'(a);
      #1 d = rdata;
   endtask

   task automatic preload();
      for (int i = 0; i < 16; i++) begin
         logic [63:0] v;
         v = 64'h4000_0000 | (64'(i) << 12);
         if (i == 15) v = v | (64'h1 << 50);
         wr(32 + 2*i, v);
         wr(33 + 2*i, (64'h1 << 63) | (64'(i) << 32) | (i % 2 == 1 ? 64'd7 : 64'd5));
      end
   endtask

   task automatic operands(input vec_t v);
      wr(1, v.va);
      wr(2, 64'(v.asid) | (64'(v.any) << 40));
      wr(3, 64'(v.mask) | (64'(v.n) << 48));
      wr(4, 64'(v.ctxm));
   endtask

   task automatic survivors(output logic [15:0] s);
      logic [63:0] d;
      for (int i = 0; i < 16; i++) begin
         rd(33 + 2*i, d);
         s[i] = d[63];
      end
   endtask

   task automatic poll(output int cyc, output logic [63:0] w0);
      cyc = 0;
      rd(0, w0);
      while (w0[22:20] != 3'd0 && cyc < 100) begin
         cyc++;
         rd(0, w0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] d, w0;
      logic [15:0] s;
      int cyc, lim;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      rd(0, d);
      chk("R1 control word", d, 64'h0);
      survivors(s);
      chk("R1 entries invalid", 64'(s), 64'h0);

      // R11/R12: operand and entry readback
      wr(2, 64'h0000_0115_00AB_CDEF);
      rd(2, d);
      chk("R11 select word", d, 64'h0000_0115_00AB_CDEF);
      wr(3, (64'h3FF << 48) | 64'h55_1234_5678);
      rd(3, d);
      chk("R11 range word", d, (64'h3FF << 48) | 64'h55_1234_5678);
      preload();
      rd(32 + 2*15, d);
      chk("R12 entry va", d, (64'h1 << 50) | 64'h4000_F000);
      rd(33 + 2*6, d);
      chk("R12 entry meta", d, (64'h1 << 63) | (64'd6 << 32) | 64'd5);

      // table walk: R2..R7
      for (int k = 0; k < 9; k++) begin
         preload();
         operands(VT[k]);
         wr(0, 64'h11);
         lim = (VT[k].n >= 16) ? 16 : int'(VT[k].n);
         cyc = 0;
         rd(0, w0);
         if (k == 0) chk("R2 active after go", {w0[22:20], w0[17:16], w0[0]}, {3'd1, 2'd2, 1'b1});
         while (w0[17:16] == 2'd2 && cyc < 100) begin
            cyc++;
            rd(0, w0);
         end
         chk($sformatf("R7 active cycles v%0d", k), 64'(cyc), 64'(lim + 1));
         chk($sformatf("R7 final ctrl v%0d", k), {w0[22:20], w0[17:16], w0[0]}, 6'b0);
         survivors(s);
         chk($sformatf("R3 R4 R5 R6 survivors v%0d", k), 64'(s), 64'(VT[k].keep));
      end

      // R8: no-op opcode
      preload();
      operands(VT[2]);
      wr(0, 64'h01);
      rd(0, d);
      chk("R8 nop ctrl", {d[22:20], d[17:16], d[0]}, 6'b0);
      survivors(s);
      chk("R8 nop entries", 64'(s), 64'hFFFF);

      // R9: reissue while active
      preload();
      operands(VT[2]);
      wr(0, 64'h11);
      rd(0, d);
      chk("R9 active before reissue", 64'(d[17:16]), 64'd2);
      wr(0, 64'h11);
      rd(0, d);
      chk("R9 exception while running", {d[17:16], d[0]}, {2'd1, 1'b1});
      poll(cyc, w0);
      chk("R9 final status", {w0[17:16], w0[0]}, {2'd1, 1'b0});
      survivors(s);
      chk("R9 walk completed", 64'(s), 64'h8000);

      // R10: writes ignored while busy
      preload();
      operands(VT[0]);
      wr(0, 64'h11);
      wr(1, 64'hDEAD);
      wr(33, (64'h1 << 63) | 64'h123);
      poll(cyc, w0);
      rd(1, d);
      chk("R10 operand kept", d, 64'h4000_3000);
      rd(33, d);
      chk("R10 entry kept", d, (64'h1 << 63) | 64'd5);
      survivors(s);
      chk("R10 purge result", 64'(s), 64'hFFF7);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule